// File: doc/BRIEF.md
# Bulk Erase Status Engine

This block models the status byte of a flash program/erase controller over a bulk erase. An accepted erase request starts a fixed sequence: a start-wait window, then a pre-program pass that drives the array to all zeros, then one or more erase attempts. While this runs, the status byte reports progress. A polling bit shows completion. A toggling bit flips on each status read, so software can tell that the engine is still working. A sticky error bit reports a verify failure, and a window bit shows that the start-wait window is still open.

A reset command aborts any operation, clears the error, and starts a recovery delay. Array reads are valid again only once that delay ends. Every delay is a parameter in clock cycles. A test input, sampled when the erase is accepted, forces every verify to fail. The engine then uses all of its attempts and reports an error.

Top module: `erase_status_top`

## Requirements
- R1: After reset, `status_o` reads 0x88 (bit 7 = 1, bit 3 = 1, all other bits 0), `busy_o` is 0 and `array_ready_o` is 1.
- R2: `start_i` sampled while idle and ready raises `busy_o` from the next cycle. Bit 7 of `status_o` reads 0 exactly while `busy_o` is 1.
- R3: Bit 3 of `status_o` reads 0 for exactly `WIN_CYC` cycles, beginning the cycle after the erase is accepted, and reads 1 otherwise.
- R4: With verify passing, `busy_o` stays high for exactly `WIN_CYC + PREP_CYC + ERASE_CYC` cycles, so the pre-program pass lies inside the busy period.
- R5: If `force_fail_i` is 1 when the erase is accepted, `busy_o` lasts `WIN_CYC + PREP_CYC + MAX_TRIES*ERASE_CYC` cycles and bit 5 then reads 1. The value of `force_fail_i` at any other time has no effect.
- R6: Bit 5 reads 0 whenever `busy_o` is 1. The error stays stored across later successful erases and is cleared only by `reset_cmd_i`.
- R7: Bit 6 inverts once for each cycle in which `rd_strobe_i` is sampled while busy. Bit 6 holds its value while idle.
- R8: `reset_cmd_i` aborts any operation. In the next cycle `status_o` reads 0x88 and `busy_o` is 0.
- R9: After `reset_cmd_i`, `array_ready_o` reads 0 for exactly `RST_CYC` cycles. `start_i` is ignored while `array_ready_o` is 0 or `busy_o` is 1.
- R10: Bits 4, 2, 1 and 0 of `status_o` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Erase request pulse |
| reset_cmd_i | input | 1 | Reset command pulse, aborts and clears |
| rd_strobe_i | input | 1 | Status read strobe |
| force_fail_i | input | 1 | Test input: verify fails for this erase |
| status_o | output | 8 | Status byte |
| busy_o | output | 1 | Erase sequence in progress |
| array_ready_o | output | 1 | Array reads valid (recovery delay over) |

## Verification
A sequencer stuck in a phase or a counter loaded off by one changes the busy length or the width of the bit-3 window. The bench measures both in cycles on each erase, so the error shows at the end of that operation. A lost or extra toggle flip shows as a wrong bit-6 parity when the operation completes. A sticky error that leaks or is cleared early shows either during the next busy period or in the byte read right after it.

// File: rtl/erase_status_pkg.sv
package erase_status_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WAIT  = 2'd1,
    PH_PREP  = 2'd2,
    PH_ERASE = 2'd3
  } phase_e;
endpackage

// File: rtl/erase_seq.sv
module erase_seq
  import erase_status_pkg::*;
#(
  parameter int WIN_CYC   = 6,
  parameter int PREP_CYC  = 4,
  parameter int ERASE_CYC = 5,
  parameter int MAX_TRIES = 3
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   abort_i,
  input  logic   fail_i,
  output phase_e phase_o,
  output logic   busy_o,
  output logic   err_o
);
  localparam int MAXC = (WIN_CYC > PREP_CYC) ? ((WIN_CYC > ERASE_CYC) ? WIN_CYC : ERASE_CYC)
                                              : ((PREP_CYC > ERASE_CYC) ? PREP_CYC : ERASE_CYC);
  localparam int CW = $clog2(MAXC + 1);
  localparam int TW = $clog2(MAX_TRIES + 1);

  phase_e        phase_q;
  logic [CW-1:0] cnt_q;
  logic [TW-1:0] tries_q;
  logic          fail_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      tries_q <= '0;
      fail_q  <= 1'b0;
      err_q   <= 1'b0;
    end else if (abort_i) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      tries_q <= '0;
      err_q   <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_WAIT;
          cnt_q   <= CW'(WIN_CYC - 1);
          tries_q <= '0;
          fail_q  <= fail_i;
        end
        PH_WAIT: if (cnt_q == '0) begin
          phase_q <= PH_PREP;
          cnt_q   <= CW'(PREP_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        PH_PREP: if (cnt_q == '0) begin
          phase_q <= PH_ERASE;
          cnt_q   <= CW'(ERASE_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        PH_ERASE: if (cnt_q == '0) begin
          // verify at end of each attempt
          if (!fail_q) phase_q <= PH_IDLE;
          else if (tries_q == TW'(MAX_TRIES - 1)) begin
            phase_q <= PH_IDLE;
            err_q   <= 1'b1;
          end else begin
            tries_q <= tries_q + 1'b1;
            cnt_q   <= CW'(ERASE_CYC - 1);
          end
        end else cnt_q <= cnt_q - 1'b1;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign busy_o  = (phase_q != PH_IDLE);
  assign err_o   = err_q;

  // R3
  wait_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_WAIT && !abort_i) |=> (phase_q == PH_WAIT || phase_q == PH_PREP));
  // R6
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !abort_i) |=> err_q);
endmodule

// File: rtl/status_toggle.sv
module status_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic busy_i,
  input  logic rd_i,
  output logic tog_o
);
  logic tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             tog_q <= 1'b0;
    else if (clr_i)          tog_q <= 1'b0;
    else if (busy_i && rd_i) tog_q <= ~tog_q;
  end

  assign tog_o = tog_q;

  // R7
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !clr_i) |=> $stable(tog_o));
  // R7
  read_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && rd_i && !clr_i) |=> (tog_o != $past(tog_o)));
endmodule

// File: rtl/reset_recovery.sv
module reset_recovery #(
  parameter int RST_CYC = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic ready_o
);
  localparam int RW = $clog2(RST_CYC + 1);
  logic [RW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clr_i)         cnt_q <= RW'(RST_CYC);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign ready_o = (cnt_q == '0);

  // R9
  clr_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !ready_o);
endmodule

// File: rtl/erase_status_top.sv
module erase_status_top
  import erase_status_pkg::*;
#(
  parameter int WIN_CYC   = 6,
  parameter int PREP_CYC  = 4,
  parameter int ERASE_CYC = 5,
  parameter int MAX_TRIES = 3,
  parameter int RST_CYC   = 7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       reset_cmd_i,
  input  logic       rd_strobe_i,
  input  logic       force_fail_i,
  output logic [7:0] status_o,
  output logic       busy_o,
  output logic       array_ready_o
);
  phase_e phase;
  logic   busy, err, tog, ready, start_ok;

  assign start_ok = start_i & ~busy & ready & ~reset_cmd_i;

  erase_seq #(
    .WIN_CYC(WIN_CYC), .PREP_CYC(PREP_CYC),
    .ERASE_CYC(ERASE_CYC), .MAX_TRIES(MAX_TRIES)
  ) u_seq (
    .clk_i, .rst_ni, .start_i(start_ok), .abort_i(reset_cmd_i),
    .fail_i(force_fail_i), .phase_o(phase), .busy_o(busy), .err_o(err)
  );

  status_toggle u_tog (
    .clk_i, .rst_ni, .clr_i(reset_cmd_i), .busy_i(busy),
    .rd_i(rd_strobe_i), .tog_o(tog)
  );

  reset_recovery #(.RST_CYC(RST_CYC)) u_rec (
    .clk_i, .rst_ni, .clr_i(reset_cmd_i), .ready_o(ready)
  );

  // error hidden while running
  assign status_o      = {~busy, tog, err & ~busy, 1'b0, ~(phase == PH_WAIT), 3'b000};
  assign busy_o        = busy;
  assign array_ready_o = ready;

  // R6
  err_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !status_o[5]);
  // R9
  no_start_unready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !array_ready_o |=> !$rose(busy_o));
  // R8
  abort_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_cmd_i |=> (!busy_o && status_o == 8'h88));
  // R3
  window_on_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !status_o[3]);
  // R10
  spare_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[4] == 1'b0 && status_o[2:0] == 3'b000));
endmodule

// File: tb/sim_erase_status_top.sv
`timescale 1ns/1ps
module sim_erase_status_top;
  localparam int WIN = 6, PREP = 4, ERS = 5, TRIES = 3, RCYC = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, rcmd = 0, rd = 0, ffail = 0;
  logic [7:0] st;
  logic busy, ready;
  int n_chk = 0, n_bad = 0;
  logic exp_tog = 0, exp_err = 0;
  bit done = 0;

  always #5 clk = ~clk;

  erase_status_top #(.WIN_CYC(WIN), .PREP_CYC(PREP), .ERASE_CYC(ERS),
                     .MAX_TRIES(TRIES), .RST_CYC(RCYC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .reset_cmd_i(rcmd),
    .rd_strobe_i(rd), .force_fail_i(ffail), .status_o(st), .busy_o(busy),
    .array_ready_o(ready)
  );

  function automatic int busy_len(bit fail);
    return WIN + PREP + ERS * (fail ? TRIES : 1);
  endfunction

  function automatic logic [7:0] idle_byte(logic t, logic e);
    return {1'b1, t, e, 1'b0, 1'b1, 3'b000};
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // one erase; inject asks for a stray start mid-run
  task automatic run_erase(bit fail, bit inject);
    int nb = 0, nw = 0, reads = 0, bad7 = 0, bad5 = 0;
    @(negedge clk); start = 1; ffail = fail;
    @(negedge clk); start = 0;
    while (busy && nb < 1000) begin
      nb++;
      if (!st[3]) nw++;
      if (st[7]) bad7++;
      if (st[5]) bad5++;
      rd = 1'($urandom % 2);
      if (rd) reads++;
      ffail = 1'($urandom % 2);
      start = inject && (nb == 3);
      @(negedge clk);
    end
    rd = 0; start = 0; ffail = 0;
    exp_tog = exp_tog ^ 1'(reads % 2);
    if (fail) exp_err = 1;
    check(fail ? "R5 busy length" : "R4 busy length", nb, busy_len(fail));
    check("R3 window cycles", nw, WIN);
    check("R2 bit7 low while busy", bad7, 0);
    check("R6 bit5 masked while busy", bad5, 0);
    check("R7 toggle parity / R5 R6 error / R10 byte", st, idle_byte(exp_tog, exp_err));
  endtask

  task automatic reset_cmd(bit try_start);
    int nlow = 0;
    @(negedge clk); rcmd = 1;
    @(negedge clk); rcmd = 0;
    exp_tog = 0; exp_err = 0;
    check("R8 abort busy", busy, 0);
    check("R8 abort byte", st, 8'h88);
    while (!ready && nlow < 1000) begin
      nlow++;
      start = try_start && (nlow == 2);
      @(negedge clk);
      start = 0;
      if (try_start && nlow == 2) check("R9 start ignored in recovery", busy, 0);
    end
    check("R9 recovery cycles", nlow, RCYC);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 reset byte", st, 8'h88);
    check("R1 reset busy", busy, 0);
    check("R1 reset ready", ready, 1);
    rst_n = 1;
    @(negedge clk);

    run_erase(0, 0);
    run_erase(1, 1);
    // idle reads do not flip bit 6
    repeat (4) begin @(negedge clk); rd = 1; end
    @(negedge clk); rd = 0;
    check("R7 idle hold", st, idle_byte(exp_tog, exp_err));
    run_erase(0, 0);  // error stays sticky
    check("R6 sticky after pass", st[5], 1);
    reset_cmd(1);
    check("R6 cleared by reset", st[5], 0);

    // abort mid-run
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    repeat (5) @(negedge clk);
    reset_cmd(0);

    for (int i = 0; i < 20; i++) begin
      int sel = $urandom % 4;
      if (sel == 3) begin
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        repeat (1 + $urandom % 20) @(negedge clk);
        reset_cmd(1'($urandom % 2));
      end else begin
        run_erase(sel == 2, 1'($urandom % 2));
      end
      check("R10 spare bits", {st[4], st[2:0]}, 0);
    end

    done = 1;
    summary();
  end
endmodule